// File: doc/BRIEF.md
# Indexed Colour-Map Controller

This block holds the colour table of an indexed-colour display path. It has 256 main colour entries and 4 overlay entries, and each entry is an 8-bit red, green and blue triple. Software on a 32-bit register bus selects an entry by writing an index. It then moves through the three components of that entry with repeated accesses to a single data offset. A three-step component counter orders those accesses, and the index advances by itself after each triple. Reads and writes share the same counter and the same index.

A second data offset reaches the overlay bank. It uses the two low bits of the current index and follows the same sequencing. A combinational lookup port, separate from the bus, turns a pixel index or an overlay select into a 24-bit colour for the scan-out path.

Top module: `palette_dac`

## Requirements
- R1: A full-width write to offset 0x0 loads the index from `bus_wdata[31:24]` and returns the component counter to red (encoding 0), including in the middle of a triple.
- R2: Each full-width write to offset 0x4 stores `bus_wdata[31:24]` into the current component of main entry `index`, in the order red (0), green (1), blue (2); bits 23:0 are ignored.
- R3: The access that handles blue increments the index modulo 256, so 255 wraps to 0, and returns the counter to red.
- R4: A full-width write to offset 0xC stores into overlay entry `index[1:0]` with the same component order and the same increment after blue; main entries are untouched.
- R5: A full-width read at any offset returns the current component of main entry `index` in `bus_rdata[31:24]` with bits 23:0 zero. It advances the same counter and index that writes use, so reads and writes may be interleaved within one triple.
- R6: After reset every component is 0x00, except main entry 255 and overlay entries 0 and 2, which are 0xFF in all three components. The index and the counter are 0.
- R7: An access whose byte enables `bus_be` are not all ones has no effect on the table, the index or the counter, and `bus_rdata` is zero whenever no full-width read is in progress.
- R8: A full-width write to any offset other than 0x0, 0x4 and 0xC has no effect.
- R9: `lk_color` = {red, green, blue} of overlay entry `lk_ovl_sel` when `lk_ovl_en` is 1, and of main entry `lk_index` otherwise. It is combinational, so a component written at one clock edge appears during the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during the read cycle |
| lk_index | input | 8 | Pixel index for lookup |
| lk_ovl_en | input | 1 | Select the overlay bank for lookup |
| lk_ovl_sel | input | 2 | Overlay entry for lookup |
| lk_color | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The corner that is hardest to reach is the wrap of the index from 255 to 0 while the counter is somewhere in a triple. Reaching it needs an index load followed by exactly the right number of mixed reads and writes. The same applies to the overlay alias, where an index whose low bits select an overlay entry must be advanced across several triples. The stimulus reaches these states with directed sequences: an index load at 255 followed by reads, then by writes, and overlay writes begun at an index ending in binary 10. Long random runs of mixed accesses then cover interleaved read and write triples. A behavioural model is compared against the outputs on every cycle, and a sweep of the lookup port after reset covers all 260 entries.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned CW    = 8;

    localparam int unsigned OFS_INDEX = 0;
    localparam int unsigned OFS_MAIN  = 4;
    localparam int unsigned OFS_OVL   = 12;

    typedef enum logic [1:0] {
        COMP_RED = 2'd0,
        COMP_GRN = 2'd1,
        COMP_BLU = 2'd2
    } comp_e;

    typedef struct packed {
        logic [CW-1:0] red;
        logic [CW-1:0] grn;
        logic [CW-1:0] blu;
    } rgb_t;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFS_W-1:0] acc_addr,
    input  logic [3:0]       acc_be,
    input  logic [BUS_W-1:0] acc_wdata,
    output logic [IDX_W-1:0] cur_idx,
    output comp_e            cur_comp,
    output logic             st_we,
    output logic             st_ovl,
    output logic [CW-1:0]    st_byte,
    output logic             rd_go
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        comp_e            comp;
    } seq_t;

    seq_t seq_d, seq_q;
    logic go, wr_index, wr_main, wr_ovl, step;

    always_comb begin
        go       = acc_valid && (&acc_be);
        wr_index = go && acc_write && (acc_addr == OFS_W'(OFS_INDEX));
        wr_main  = go && acc_write && (acc_addr == OFS_W'(OFS_MAIN));
        wr_ovl   = go && acc_write && (acc_addr == OFS_W'(OFS_OVL));
        rd_go    = go && !acc_write;
        step     = wr_main || wr_ovl || rd_go;
        st_we    = wr_main || wr_ovl;
        st_ovl   = wr_ovl;
        st_byte  = acc_wdata[BUS_W-1 -: CW];

        seq_d = seq_q;
        if (wr_index) begin
            seq_d.idx  = acc_wdata[BUS_W-1 -: IDX_W];
            seq_d.comp = COMP_RED;
        end else if (step) begin
            unique case (seq_q.comp)
                COMP_RED: seq_d.comp = COMP_GRN;
                COMP_GRN: seq_d.comp = COMP_BLU;
                default: begin
                    seq_d.comp = COMP_RED;
                    seq_d.idx  = seq_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{idx: '0, comp: COMP_RED};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cur_idx  = seq_q.idx;
    assign cur_comp = seq_q.comp;
endmodule

// File: rtl/pal_entry.sv
module pal_entry
    import pal_pkg::*;
#(
    parameter bit WHITE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  comp_e         comp,
    input  logic [CW-1:0] wr_byte,
    output rgb_t          q
);
    rgb_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (hit) begin
            unique case (comp)
                COMP_RED: ent_d.red = wr_byte;
                COMP_GRN: ent_d.grn = wr_byte;
                COMP_BLU: ent_d.blu = wr_byte;
                default:  ent_d = ent_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= WHITE ? '1 : '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign q = ent_q;
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned OVL_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 ovl,
    input  logic [IDX_W-1:0]     idx,
    input  comp_e                comp,
    input  logic [CW-1:0]        wr_byte,
    input  logic [IDX_W-1:0]     lk_idx,
    input  logic                 lk_ovl_en,
    input  logic [OVL_SEL_W-1:0] lk_ovl_sel,
    output rgb_t                 rd_rgb,
    output rgb_t                 lk_rgb
);
    localparam int unsigned N_MAIN = 1 << IDX_W;
    localparam int unsigned N_OVL  = 1 << OVL_SEL_W;

    rgb_t main_q [N_MAIN];
    rgb_t ovl_q  [N_OVL];

    for (genvar e = 0; e < N_MAIN; e++) begin : g_main
        logic hit;
        rgb_t q;
        assign hit = we && !ovl && (idx == IDX_W'(e));
        pal_entry #(.WHITE(e == N_MAIN - 1)) u_ent (
            .clk(clk), .rst_n(rst_n), .hit(hit), .comp(comp),
            .wr_byte(wr_byte), .q(q)
        );
        assign main_q[e] = q;
    end

    for (genvar o = 0; o < N_OVL; o++) begin : g_ovl
        logic hit;
        rgb_t q;
        assign hit = we && ovl && (idx[OVL_SEL_W-1:0] == OVL_SEL_W'(o));
        pal_entry #(.WHITE(o == 0 || o == 2)) u_ent (
            .clk(clk), .rst_n(rst_n), .hit(hit), .comp(comp),
            .wr_byte(wr_byte), .q(q)
        );
        assign ovl_q[o] = q;
    end

    always_comb begin
        rd_rgb = main_q[idx];
        lk_rgb = lk_ovl_en ? ovl_q[lk_ovl_sel] : main_q[lk_idx];
    end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned OVL_SEL_W = 2,
    parameter int unsigned OFS_W     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [OFS_W-1:0]     bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [IDX_W-1:0]     lk_index,
    input  logic                 lk_ovl_en,
    input  logic [OVL_SEL_W-1:0] lk_ovl_sel,
    output logic [3*CW-1:0]      lk_color
);
    logic [IDX_W-1:0] cur_idx;
    comp_e            cur_comp;
    logic             st_we, st_ovl, rd_go;
    logic [CW-1:0]    st_byte, comp_byte;
    rgb_t             rd_rgb, lk_rgb;

    pal_seq #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(bus_valid), .acc_write(bus_write), .acc_addr(bus_addr),
        .acc_be(bus_be), .acc_wdata(bus_wdata),
        .cur_idx(cur_idx), .cur_comp(cur_comp),
        .st_we(st_we), .st_ovl(st_ovl), .st_byte(st_byte), .rd_go(rd_go)
    );

    pal_store #(.IDX_W(IDX_W), .OVL_SEL_W(OVL_SEL_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .ovl(st_ovl), .idx(cur_idx), .comp(cur_comp),
        .wr_byte(st_byte),
        .lk_idx(lk_index), .lk_ovl_en(lk_ovl_en), .lk_ovl_sel(lk_ovl_sel),
        .rd_rgb(rd_rgb), .lk_rgb(lk_rgb)
    );

    always_comb begin
        unique case (cur_comp)
            COMP_RED: comp_byte = rd_rgb.red;
            COMP_GRN: comp_byte = rd_rgb.grn;
            COMP_BLU: comp_byte = rd_rgb.blu;
            default:  comp_byte = '0;
        endcase
        bus_rdata = rd_go ? {comp_byte, {(BUS_W-CW){1'b0}}} : '0;
        lk_color  = lk_rgb;
    end
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned OFS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [OFS_W-1:0] bus_addr,
    input logic [3:0]       bus_be,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [IDX_W-1:0] cur_idx,
    input logic [1:0]       cur_comp
);
    logic full, step_acc, other_wr;
    assign full     = bus_valid && (bus_be == 4'hF);
    assign step_acc = full && (!bus_write || bus_addr == OFS_W'(4) || bus_addr == OFS_W'(12));
    assign other_wr = full && bus_write && bus_addr != OFS_W'(0)
                      && bus_addr != OFS_W'(4) && bus_addr != OFS_W'(12);

    assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && bus_write && bus_addr == OFS_W'(0))
        |=> (cur_idx == $past(bus_wdata[31 -: IDX_W]) && cur_comp == 2'd0));

    assert_comp_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_comp != 2'd3);

    assert_blue_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_acc && cur_comp == 2'd2)
        |=> (cur_comp == 2'd0 && cur_idx == IDX_W'($past(cur_idx) + 1'b1)));

    assert_rdata_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[23:0] == 24'd0);

    assert_partial_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_be != 4'hF) |=> ($stable(cur_idx) && $stable(cur_comp)));

    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && !bus_write) |-> bus_rdata == 32'd0);

    assert_other_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> ($stable(cur_idx) && $stable(cur_comp)));
endmodule

bind palette_dac palette_dac_chk #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cur_idx(cur_idx), .cur_comp(cur_comp)
);

// File: tb/tb_palette_dac.sv
module tb_palette_dac;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lk_index = '0;
    logic        lk_ovl_en = 1'b0;
    logic [1:0]  lk_ovl_sel = '0;
    logic [23:0] lk_color;

    int m_r[260], m_g[260], m_b[260];
    int m_idx, m_st;
    int n_chk = 0, n_fail = 0;
    bit lk_hold = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_dac dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lk_index(lk_index), .lk_ovl_en(lk_ovl_en),
        .lk_ovl_sel(lk_ovl_sel), .lk_color(lk_color)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 260; i++) begin
            m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
        end
        foreach (m_r[i]) if (i == 255 || i == 256 || i == 258) begin
            m_r[i] = 255; m_g[i] = 255; m_b[i] = 255;
        end
        m_idx = 0; m_st = 0;
    endtask

    function automatic int comp_of(int e, int st);
        return (st == 0) ? m_r[e] : (st == 1) ? m_g[e] : m_b[e];
    endfunction

    task automatic step(bit v, bit w, logic [11:0] a, logic [31:0] d,
                        logic [3:0] be, string req);
        logic [31:0] exp_rd;
        logic [23:0] exp_lk;
        int e;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; bus_be = be;
        if (!lk_hold) begin
            lk_index = 8'($urandom); lk_ovl_en = 1'($urandom); lk_ovl_sel = 2'($urandom);
        end
        #1;
        exp_rd = (v && !w && be == 4'hF) ? {8'(comp_of(m_idx, m_st)), 24'd0} : 32'd0;
        chk(req, bus_rdata, exp_rd);
        e = lk_ovl_en ? 256 + int'(lk_ovl_sel) : int'(lk_index);
        exp_lk = {8'(m_r[e]), 8'(m_g[e]), 8'(m_b[e])};
        chk(lk_hold ? req : "R9", {8'd0, lk_color}, {8'd0, exp_lk});
        @(posedge clk);
        if (v && be == 4'hF) begin
            if (w && a == 12'h0) begin
                m_idx = int'(d[31:24]); m_st = 0;
            end else if (!w || a == 12'h4 || a == 12'hC) begin
                if (w) begin
                    e = (a == 12'hC) ? 256 + (m_idx % 4) : m_idx;
                    case (m_st)
                        0: m_r[e] = int'(d[31:24]);
                        1: m_g[e] = int'(d[31:24]);
                        default: m_b[e] = int'(d[31:24]);
                    endcase
                end
                if (m_st == 2) begin m_st = 0; m_idx = (m_idx + 1) % 256; end
                else m_st++;
            end
        end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] b, string req);
        step(1, 1, a, {b, 24'($urandom)}, 4'hF, req);
    endtask

    task automatic rd(logic [11:0] a, string req);
        step(1, 0, a, 32'($urandom), 4'hF, req);
    endtask

    task automatic look(logic [7:0] i, bit en, logic [1:0] s, string req);
        lk_hold = 1; lk_index = i; lk_ovl_en = en; lk_ovl_sel = s;
        step(0, 0, 12'h0, 32'h0, 4'h0, req);
        lk_hold = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R6: reset contents over the whole table, and idle read data
        for (int i = 0; i < 256; i++) look(8'(i), 0, 2'd0, "R6");
        for (int i = 0; i < 4; i++) look(8'd0, 1, 2'(i), "R6");
        // R1/R5/R3: load 255, read back white, wrap to 0
        wr(12'h0, 8'd255, "R1");
        repeat (3) rd(12'h4, "R5");
        rd(12'h4, "R3");
        // R2: write entry 5 with noise in low bits, then look it up (R9)
        wr(12'h0, 8'd5, "R1");
        wr(12'h4, 8'h12, "R2"); wr(12'h4, 8'h34, "R2"); wr(12'h4, 8'h56, "R2");
        look(8'd5, 0, 2'd0, "R9");
        look(8'd6, 0, 2'd0, "R9");
        // R3: write triple at 255 wraps to 0
        wr(12'h0, 8'd255, "R1");
        wr(12'h4, 8'hA1, "R3"); wr(12'h4, 8'hA2, "R3"); wr(12'h4, 8'hA3, "R3");
        wr(12'h4, 8'h77, "R3");
        look(8'd255, 0, 2'd0, "R3"); look(8'd0, 0, 2'd0, "R3");
        // R1: index load in mid-triple restarts at red
        wr(12'h0, 8'd9, "R1"); wr(12'h4, 8'h01, "R1");
        wr(12'h0, 8'd10, "R1"); wr(12'h4, 8'h02, "R1");
        look(8'd9, 0, 2'd0, "R1"); look(8'd10, 0, 2'd0, "R1");
        // R4: overlay writes via index low bits, across two triples
        wr(12'h0, 8'h0E, "R4");
        for (int i = 0; i < 6; i++) wr(12'hC, 8'(8'h40 + i), "R4");
        for (int i = 0; i < 4; i++) look(8'd0, 1, 2'(i), "R4");
        look(8'h0E, 0, 2'd0, "R4");
        // R5: reads and writes share the counter
        wr(12'h0, 8'd7, "R1");
        wr(12'h4, 8'hC1, "R5"); rd(12'h4, "R5"); wr(12'h4, 8'hC3, "R5");
        look(8'd7, 0, 2'd0, "R5"); rd(12'h4, "R5");
        // R7: partial byte enables do nothing
        step(1, 1, 12'h0, 32'h3300_0000, 4'h7, "R7");
        step(1, 1, 12'h4, 32'hEE00_0000, 4'h0, "R7");
        step(1, 0, 12'h4, 32'h0, 4'hE, "R7");
        rd(12'h4, "R7");
        look(8'd8, 0, 2'd0, "R7");
        // R8: other offsets ignored on write, reads act at any offset
        wr(12'h8, 8'h55, "R8"); wr(12'h10, 8'h66, "R8"); wr(12'hFFC, 8'h67, "R8");
        rd(12'h20, "R8"); rd(12'h8, "R8");
        look(8'd8, 0, 2'd0, "R8");
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [11:0] a;
            k = $urandom_range(0, 4);
            a = (k == 0) ? 12'h0 : (k == 1) ? 12'h4 : (k == 2) ? 12'hC :
                (k == 3) ? 12'h8 : 12'h40;
            step(1'($urandom_range(0, 7) != 0), 1'($urandom), a, 32'($urandom),
                 ($urandom_range(0, 9) == 0) ? 4'h3 : 4'hF, "R5");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule